// File: doc/BRIEF.md
# BCD-Programmed Synthesizer Divider Pair

This block holds the two counters that feed the phase comparator of a frequency-synthesizer loop. The reference divider runs on the crystal clock and produces the comparison frequency by dividing by 1024, or by 2048 when the halving select is high. Halving selects a channel step half as wide.

The feedback divider runs on the mixed-down oscillator clock. It divides by a modulus N given as a three-digit BCD word: a 2-bit hundreds digit and 4-bit tens and units digits, so N runs from 1 to 399. In a locked loop, raising or lowering N by one moves the oscillator by one channel step.

Each divided output is a pulse one input clock wide, once per period. A code that is not proper BCD, or the all-zero code, raises a flag and is not taken. The divider keeps its last accepted modulus. A new modulus, or a new reference select, is taken only when the running period ends, so a retune never makes a short period.

Top module: `synth_div_pair`

## Requirements
- R1: With code `mod_bcd` = {hundreds in bits 9:8, tens in bits 7:4, units in bits 3:0} worth N, `fb_tick` pulses once every N `clk_fb` cycles. For example, 0x146 gives 146, binary 10_0100_0101 gives 245, binary 11_1001_1001 gives 399, and 0x001 gives a pulse on every cycle.
- R2: For N of 2 or more, each `fb_tick` pulse lasts exactly one `clk_fb` cycle.
- R3: `code_bad` is high, combinationally from `mod_bcd`, whenever bits 7:4 or bits 3:0 exceed 9 or the whole code is zero. Otherwise it is low.
- R4: A code flagged by `code_bad` has no effect: `fb_tick` keeps the period of the last accepted modulus.
- R5: A modulus change takes effect only when the running feedback period ends. The period in progress keeps its old length, and the next period has the new length.
- R6: `ref_tick` pulses for one `clk_ref` cycle every 1024 cycles when `ref_half` is 0, and every 2048 cycles when it is 1.
- R7: A change of `ref_half` takes effect only when the running reference period ends.
- R8: Synchronous reset `rst` loads each counter with a full period. It takes the current code if that code is valid, and a modulus of 1 if it is not. The first `fb_tick` comes N-1 `clk_fb` edges after reset is released, and the first `ref_tick` comes 1023 or 2047 `clk_ref` edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal clock for the reference divider |
| clk_fb | input | 1 | Mixed-down oscillator clock for the feedback divider |
| rst | input | 1 | Synchronous reset, active high, seen by both clocks |
| ref_half | input | 1 | 0 divides by 1024, 1 divides by 2048 |
| mod_bcd | input | 10 | Feedback modulus: hundreds[9:8], tens[7:4], units[3:0] |
| ref_tick | output | 1 | One-cycle pulse at the comparison frequency |
| fb_tick | output | 1 | One-cycle pulse at the divided oscillator frequency |
| code_bad | output | 1 | The present modulus code is rejected |

## Verification
The terminal count and a modulus change can land in the same clock. On that edge the reload must pick the new code if it is valid, and the held code if it is not. The bench provokes this in two ways. It writes a new code at the negedge of the pulse cycle, so the reload edge sees it at once. It also writes codes in the middle of a period, so the edge that sees them is not a terminal edge. A behavioural integer model, compared on every clock, judges both cases, and explicit period measurements check that no period is shortened.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int DIG_W   = 4;
  localparam int HUND_W  = 2;
  localparam int NUM_DIG = 3;
  localparam int CODE_W  = HUND_W + (NUM_DIG - 1) * DIG_W;

  typedef struct packed {
    logic [HUND_W-1:0] hund;
    logic [DIG_W-1:0]  tens;
    logic [DIG_W-1:0]  units;
  } bcd_code_t;

  // accepted codes: both lower digits are decimal and the word is not zero
  function automatic logic code_ok(bcd_code_t c);
    return (c.tens <= 4'd9) && (c.units <= 4'd9) && (c != '0);
  endfunction

  function automatic int unsigned code_value(bcd_code_t c);
    return 100 * int'(c.hund) + 10 * int'(c.tens) + int'(c.units);
  endfunction
endpackage

// File: rtl/sd_bcd_digit.sv
module sd_bcd_digit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val,
  output logic         is_zero
);
  localparam logic [W-1:0] WRAP = (W >= 4) ? W'(9) : {W{1'b1}};

  assign is_zero = (val == '0);

  always_ff @(posedge clk) begin
    if (load)     val <= load_val;
    else if (dec) val <= is_zero ? WRAP : val - W'(1);
  end

  AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (rst)
    int'(val) <= 9) else $error("digit left decimal range"); // R1
endmodule

// File: rtl/sd_fb_div.sv
module sd_fb_div
  import synth_div_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_MOD = CODE_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic              tick,
  output logic              bad
);
  logic              in_ok;
  logic              term;
  logic              load;
  logic [CODE_W-1:0] held;
  logic [CODE_W-1:0] nxt_mod;
  logic [CODE_W-1:0] cnt;
  logic [NUM_DIG-1:0] dig_zero;
  logic [NUM_DIG-1:0] dec_chain;

  assign in_ok   = code_ok(bcd_code_t'(code_in));
  assign bad     = !in_ok;
  assign nxt_mod = in_ok ? code_in : (rst ? RST_MOD : held);
  assign term    = (cnt == CODE_W'(1));
  assign load    = rst | term;
  assign tick    = term;
  assign dec_chain[0] = 1'b1;

  generate
    for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
      localparam int W  = (i == NUM_DIG - 1) ? HUND_W : DIG_W;
      localparam int LO = i * DIG_W;
      sd_bcd_digit #(.W(W)) u_dig (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .dec      (dec_chain[i]),
        .load_val (nxt_mod[LO +: W]),
        .val      (cnt[LO +: W]),
        .is_zero  (dig_zero[i])
      );
      if (i < NUM_DIG - 1) begin : g_borrow
        assign dec_chain[i+1] = dec_chain[i] & dig_zero[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (load) held <= nxt_mod;
  end

  AST_HELD_ONLY_AT_TERM: assert property (@(posedge clk) disable iff (rst)
    !term |=> $stable(held)) else $error("modulus changed mid-period"); // R5
  AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (term && bad) |=> $stable(held)) else $error("rejected code taken"); // R4
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt == held)) else $error("reload mismatch"); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(&dig_zero)) else $error("counter reached zero"); // R1
  AST_CNT_WITHIN_MOD: assert property (@(posedge clk) disable iff (rst)
    code_value(bcd_code_t'(cnt)) <= code_value(bcd_code_t'(held))) else $error("count above modulus"); // R5
  AST_FB_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    term |=> (!term || held == CODE_W'(1))) else $error("wide feedback pulse"); // R2
endmodule

// File: rtl/sd_ref_div.sv
module sd_ref_div #(
  parameter int LOG2 = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic half,
  output logic tick
);
  localparam int CW = LOG2 + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;
  logic          term;

  assign reload = half ? {CW{1'b1}} : {1'b0, {LOG2{1'b1}}};
  assign term   = (cnt == '0);
  assign tick   = term;

  always_ff @(posedge clk) begin
    if (rst || term) cnt <= reload;
    else             cnt <= cnt - CW'(1);
  end

  AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
    !term |=> (cnt == $past(cnt) - CW'(1))) else $error("reference skipped"); // R6
  AST_REF_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    term |=> !term) else $error("wide reference pulse"); // R6
  AST_REF_SELECT_AT_TERM: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt[CW-1] == $past(half))) else $error("select not applied"); // R7
endmodule

// File: rtl/synth_div_pair.sv
module synth_div_pair
  import synth_div_pkg::*;
#(
  parameter int                REF_LOG2 = 10,
  parameter logic [CODE_W-1:0] RST_MOD  = CODE_W'(1)
) (
  input  logic              clk_ref,
  input  logic              clk_fb,
  input  logic              rst,
  input  logic              ref_half,
  input  logic [CODE_W-1:0] mod_bcd,
  output logic              ref_tick,
  output logic              fb_tick,
  output logic              code_bad
);
  sd_ref_div #(.LOG2(REF_LOG2)) u_ref (
    .clk  (clk_ref),
    .rst  (rst),
    .half (ref_half),
    .tick (ref_tick)
  );

  sd_fb_div #(.RST_MOD(RST_MOD)) u_fb (
    .clk     (clk_fb),
    .rst     (rst),
    .code_in (mod_bcd),
    .tick    (fb_tick),
    .bad     (code_bad)
  );
endmodule

// File: tb/sim_synth_div_pair.sv
module sim_synth_div_pair;
  logic       clk_fb = 1'b0;
  logic       clk_ref = 1'b0;
  logic       rst = 1'b1;
  logic       ref_half = 1'b0;
  logic [9:0] mod_bcd = 10'h146;
  logic       ref_tick, fb_tick, code_bad;

  synth_div_pair u0 (
    .clk_ref(clk_ref), .clk_fb(clk_fb), .rst(rst), .ref_half(ref_half),
    .mod_bcd(mod_bcd), .ref_tick(ref_tick), .fb_tick(fb_tick), .code_bad(code_bad)
  );

  always #10 clk_fb = ~clk_fb;
  always #7  clk_ref = ~clk_ref;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int m_cnt = 0;
  int m_held = 0;
  int m_rcnt = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic bit m_ok(logic [9:0] c);
    return (c[7:4] < 4'd10) && (c[3:0] < 4'd10) && (c != 10'd0);
  endfunction

  function automatic int m_val(logic [9:0] c);
    return int'(c[9:8]) * 100 + int'(c[7:4]) * 10 + int'(c[3:0]);
  endfunction

  // behavioural reference: integer period counters
  always @(posedge clk_fb) begin
    if (rst) begin
      m_held = m_ok(mod_bcd) ? m_val(mod_bcd) : 1;
      m_cnt  = m_held;
    end else if (m_cnt == 1) begin
      if (m_ok(mod_bcd)) m_held = m_val(mod_bcd);
      m_cnt = m_held;
    end else begin
      m_cnt = m_cnt - 1;
    end
  end

  always @(posedge clk_ref) begin
    if (rst || m_rcnt == 0) m_rcnt = ref_half ? 2047 : 1023;
    else                    m_rcnt = m_rcnt - 1;
  end

  always @(negedge clk_fb)
    if (!finished) chk(fb_tick == (m_cnt == 1), "R1 fb_tick vs model", int'(fb_tick), int'(m_cnt == 1));

  always @(negedge clk_ref)
    if (!finished) chk(ref_tick == (m_rcnt == 0), "R6 ref_tick vs model", int'(ref_tick), int'(m_rcnt == 0));

  task automatic fb_gap(output int g);
    do @(negedge clk_fb); while (!fb_tick);
    g = 0;
    do begin @(negedge clk_fb); g++; end while (!fb_tick);
  endtask

  task automatic ref_gap(output int g);
    do @(negedge clk_ref); while (!ref_tick);
    g = 0;
    do begin @(negedge clk_ref); g++; end while (!ref_tick);
  endtask

  initial begin
    repeat (150000) @(posedge clk_fb);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    // R8: reset with code 146
    repeat (3) @(negedge clk_fb);
    rst = 1'b0;
    #1;
    chk(fb_tick == 1'b0, "R8 fb_tick after reset", int'(fb_tick), 0);
    chk(ref_tick == 1'b0, "R8 ref_tick after reset", int'(ref_tick), 0);
    chk(code_bad == 1'b0, "R3 code 146 accepted", int'(code_bad), 0);
    n = 0;
    do begin @(negedge clk_fb); n++; end while (!fb_tick);
    chk(n == 145, "R8 first fb pulse edges", n, 145);
    @(negedge clk_fb);
    chk(fb_tick == 1'b0, "R2 pulse one cycle wide", int'(fb_tick), 0);
    fb_gap(n);
    chk(n == 146, "R1 divide 146", n, 146);

    // R5: change in mid-period
    do @(negedge clk_fb); while (!fb_tick);
    n = 0;
    do begin
      @(negedge clk_fb); n++;
      if (n == 5) mod_bcd = 10'b10_0100_0101;
    end while (!fb_tick);
    chk(n == 146, "R5 running period kept", n, 146);
    fb_gap(n);
    chk(n == 245, "R1 divide 245", n, 245);

    // terminal and new code on the same edge
    mod_bcd = 10'b11_1001_1001;
    fb_gap(n);
    chk(n == 399, "R1 divide 399", n, 399);

    // R3/R4: rejected codes
    mod_bcd = 10'h1A5;
    #1 chk(code_bad == 1'b1, "R3 tens above 9", int'(code_bad), 1);
    fb_gap(n);
    chk(n == 399, "R4 bad tens ignored", n, 399);
    mod_bcd = 10'h09F;
    #1 chk(code_bad == 1'b1, "R3 units above 9", int'(code_bad), 1);
    mod_bcd = 10'h000;
    #1 chk(code_bad == 1'b1, "R3 zero code", int'(code_bad), 1);
    fb_gap(n);
    chk(n == 399, "R4 zero code ignored", n, 399);

    mod_bcd = 10'h001;
    #1 chk(code_bad == 1'b0, "R3 code 1 accepted", int'(code_bad), 0);
    fb_gap(n);
    fb_gap(n);
    chk(n == 1, "R1 divide 1", n, 1);

    // R8: reset with invalid code falls back to modulus 1
    @(negedge clk_fb);
    mod_bcd = 10'h000;
    rst = 1'b1;
    repeat (3) @(negedge clk_fb);
    rst = 1'b0;
    #1 chk(fb_tick == 1'b1, "R8 reset fallback modulus 1", int'(fb_tick), 1);
    fb_gap(n);
    chk(n == 1, "R8 fallback period", n, 1);
    mod_bcd = 10'h146;
    fb_gap(n);
    fb_gap(n);
    chk(n == 146, "R1 divide 146 after fallback", n, 146);

    // R6/R7: reference divider
    ref_gap(n);
    chk(n == 1024, "R6 divide 1024", n, 1024);
    do @(negedge clk_ref); while (!ref_tick);
    n = 0;
    do begin
      @(negedge clk_ref); n++;
      if (n == 10) ref_half = 1'b1;
    end while (!ref_tick);
    chk(n == 1024, "R7 select waits for terminal", n, 1024);
    ref_gap(n);
    chk(n == 2048, "R6 divide 2048", n, 2048);

    repeat (2) @(negedge clk_fb);
    finish_run();
  end
endmodule